// File: doc/BRIEF.md
# Return Address Stack with Fault Guard

This block holds the return addresses of nested subroutine calls in a last-in, first-out store and watches for misuse of that store. A push request saves an address on top of the stack. A pop request hands back the most recent address on the following cycle. The block counts how many entries are in use.

Two faults are detected. The first is a push that reaches or goes beyond the last entry. The second is a pop from an empty stack. Each fault sets its own sticky flag. A configuration input decides what else happens. With the input low, the fault is only recorded. With it high, the block also sends a one-cycle reset request to the chip's reset sequencer.

The flags stay set through that ordinary reset, so software can read the cause after the restart. Software clears them with a write strobe and a per-flag select. A power-on reset also clears them.

Top module: `ret_stack_guard`

## Requirements
- R1: A push saves `push_addr` and raises `depth_used` by one. A pop on a non-empty stack lowers `depth_used` by one. The entry it removes appears on `pop_addr` from the clock edge of the pop onward, and `pop_addr` holds that value until the next pop or reset. Entries come back in last-in, first-out order.
- R2: A push that brings `depth_used` to DEPTH (31) sets `full_flag`. A push made while the stack already holds DEPTH entries also sets `full_flag`, but it leaves `depth_used` unchanged and overwrites no stored entry.
- R3: A pop while `depth_used` is 0 sets `unf_flag`, drives `pop_addr` to 0 and leaves `depth_used` at 0.
- R4: With `fault_rst_en` high in the cycle of a fault, `rst_req` is high for exactly one cycle. That cycle is the one that starts at the clock edge after the edge that sets the flag.
- R5: With `fault_rst_en` low in the cycle of a fault, the flag is still set and `rst_req` stays low.
- R6: The flags are sticky. If `flag_clr_we` is high at an edge, `flag_clr_sel[0]` clears `full_flag` and `flag_clr_sel[1]` clears `unf_flag`. A select without the strobe does nothing. If a fault and a clear of the same flag arrive together, the fault wins and the flag stays set.
- R7: While `sys_rst_n` is low, `depth_used`, `pop_addr` and `rst_req` are 0 and both flags keep their value. While `por_n` is low, everything is 0, the flags included.
- R8: If push and pop are requested in the same cycle, the pop is carried out and the push is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous; clears everything |
| sys_rst_n | input | 1 | Ordinary reset, active low, asynchronous; flags are kept |
| push_req | input | 1 | Push `push_addr` on top of the stack |
| pop_req | input | 1 | Remove the top entry |
| push_addr | input | AW (21) | Return address to save |
| fault_rst_en | input | 1 | 1 = faults also request a reset |
| flag_clr_we | input | 1 | Software clear strobe |
| flag_clr_sel | input | 2 | bit 0 clears full flag, bit 1 clears underflow flag |
| pop_addr | output | AW (21) | Address returned by the most recent pop |
| depth_used | output | PW (5) | Number of entries held |
| full_flag | output | 1 | Sticky full fault flag |
| unf_flag | output | 1 | Sticky underflow fault flag |
| rst_req | output | 1 | One-cycle device reset request |

## Verification
The assertions check the following on every cycle:
- `depth_used` never goes past the depth, and a push onto a full stack leaves it unchanged.
- A pop from an empty stack returns zero.
- Every fault sets its flag.
- A flag stays set unless the strobe clears it.
- A reset request is never issued unless there was an enabled fault two edges earlier.

Other behaviour only the bench scenarios can show, by comparing against a reference model:
- Last-in, first-out ordering across long random runs.
- That the entry saved last is not overwritten by pushes onto a full stack.
- The exact cycle of the reset pulse.
- That the flags survive an ordinary reset but not a power-on reset.

// File: rtl/rsg_pkg.sv
package rsg_pkg;
   // One bit per fault kind; reused for events and for sticky flags
   typedef struct packed {
      logic full;
      logic unf;
   } rsg_fault_t;
endpackage

// File: rtl/rsg_store.sv
module rsg_store #(
   parameter int DEPTH = 31,
   parameter int AW    = 21,
   parameter int PW    = 5
) (
   input  logic          clk,
   input  logic          wr_en,
   input  logic [PW-1:0] wr_idx,
   input  logic [AW-1:0] wr_data,
   input  logic [PW-1:0] rd_idx,
   output logic [AW-1:0] rd_data
);
   localparam logic [PW-1:0] TOP = PW'(DEPTH);

   logic [AW-1:0] ent [DEPTH];

   for (genvar i = 0; i < DEPTH; i++) begin : g_ent
      always_ff @(posedge clk) begin
         if (wr_en && (wr_idx == PW'(i))) ent[i] <= wr_data;
      end
   end

   // Out-of-range index (empty stack wraps to all ones) reads as zero
   always_comb begin
      rd_data = '0;
      if (rd_idx < TOP) rd_data = ent[rd_idx];
   end
endmodule

// File: rtl/rsg_ptr.sv
module rsg_ptr
   import rsg_pkg::*;
#(
   parameter int DEPTH = 31,
   parameter int AW    = 21,
   parameter int PW    = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic          pop,
   input  logic [AW-1:0] rd_data,
   output logic          wr_en,
   output logic [PW-1:0] wr_idx,
   output logic [PW-1:0] rd_idx,
   output logic [PW-1:0] cnt,
   output logic [AW-1:0] pop_addr,
   output rsg_fault_t    fault
);
   localparam logic [PW-1:0] TOP  = PW'(DEPTH);
   localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
   localparam logic [PW-1:0] ONE  = PW'(1);

   logic do_pop, do_push, empty, at_full;

   always_comb begin
      do_pop     = pop & rst_n;
      do_push    = push & ~pop & rst_n;   // pop has priority
      empty      = (cnt == '0);
      at_full    = (cnt == TOP);
      fault.unf  = do_pop & empty;
      fault.full = do_push & ((cnt == LAST) | at_full);
      wr_en      = do_push & ~at_full;
      wr_idx     = cnt;
      rd_idx     = cnt - ONE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt      <= '0;
         pop_addr <= '0;
      end else if (do_pop) begin
         if (empty) begin
            pop_addr <= '0;
         end else begin
            pop_addr <= rd_data;
            cnt      <= cnt - ONE;
         end
      end else if (wr_en) begin
         cnt <= cnt + ONE;
      end
   end

   // R1
   depth_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= TOP);

   // R2
   full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !pop && cnt == TOP) |=> (cnt == TOP));

   // R3
   empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && cnt == '0) |=> (pop_addr == '0 && cnt == '0));
endmodule

// File: rtl/rsg_flags.sv
module rsg_flags
   import rsg_pkg::*;
(
   input  logic       clk,
   input  logic       por_n,
   input  logic       rst_n,
   input  rsg_fault_t fault,
   input  logic       cfg_en,
   input  logic       clr_we,
   input  logic [1:0] clr_sel,
   output rsg_fault_t flags,
   output logic       rst_req
);
   logic evt_q;
   logic clr_full, clr_unf;

   always_comb begin
      clr_full = clr_we & clr_sel[0];
      clr_unf  = clr_we & clr_sel[1];
   end

   // Flags reset only by power-on reset; a fault beats a clear
   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         flags <= '0;
      end else begin
         flags.full <= fault.full | (flags.full & ~clr_full);
         flags.unf  <= fault.unf  | (flags.unf  & ~clr_unf);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         evt_q   <= 1'b0;
         rst_req <= 1'b0;
      end else begin
         evt_q   <= (fault.full | fault.unf) & cfg_en;
         rst_req <= evt_q;
      end
   end

   // R2
   full_set_chk: assert property (@(posedge clk) disable iff (!por_n)
      fault.full |=> flags.full);

   // R3
   unf_set_chk: assert property (@(posedge clk) disable iff (!por_n)
      fault.unf |=> flags.unf);

   // R6
   full_sticky_chk: assert property (@(posedge clk) disable iff (!por_n)
      (flags.full && !clr_full) |=> flags.full);

   // R6
   unf_sticky_chk: assert property (@(posedge clk) disable iff (!por_n)
      (flags.unf && !clr_unf) |=> flags.unf);

   // R5
   req_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |-> $past(cfg_en && (fault.full || fault.unf), 2));
endmodule

// File: rtl/ret_stack_guard.sv
module ret_stack_guard
   import rsg_pkg::*;
#(
   parameter  int DEPTH = 31,
   parameter  int AW    = 21,
   localparam int PW    = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          por_n,
   input  logic          sys_rst_n,
   input  logic          push_req,
   input  logic          pop_req,
   input  logic [AW-1:0] push_addr,
   input  logic          fault_rst_en,
   input  logic          flag_clr_we,
   input  logic [1:0]    flag_clr_sel,
   output logic [AW-1:0] pop_addr,
   output logic [PW-1:0] depth_used,
   output logic          full_flag,
   output logic          unf_flag,
   output logic          rst_req
);
   if (DEPTH < 2 || DEPTH > 1024) begin : g_bad_depth
      $error("ret_stack_guard: DEPTH must be within 2..1024");
   end
   if (AW < 1 || AW > 64) begin : g_bad_aw
      $error("ret_stack_guard: AW must be within 1..64");
   end

   logic          rst_any_n;
   logic          wr_en;
   logic [PW-1:0] wr_idx, rd_idx;
   logic [AW-1:0] rd_data;
   rsg_fault_t    fault, flags;

   assign rst_any_n  = por_n & sys_rst_n;
   assign full_flag  = flags.full;
   assign unf_flag   = flags.unf;

   rsg_store #(.DEPTH(DEPTH), .AW(AW), .PW(PW)) u_store (
      .clk     (clk),
      .wr_en   (wr_en),
      .wr_idx  (wr_idx),
      .wr_data (push_addr),
      .rd_idx  (rd_idx),
      .rd_data (rd_data)
   );

   rsg_ptr #(.DEPTH(DEPTH), .AW(AW), .PW(PW)) u_ptr (
      .clk      (clk),
      .rst_n    (rst_any_n),
      .push     (push_req),
      .pop      (pop_req),
      .rd_data  (rd_data),
      .wr_en    (wr_en),
      .wr_idx   (wr_idx),
      .rd_idx   (rd_idx),
      .cnt      (depth_used),
      .pop_addr (pop_addr),
      .fault    (fault)
   );

   rsg_flags u_flags (
      .clk     (clk),
      .por_n   (por_n),
      .rst_n   (rst_any_n),
      .fault   (fault),
      .cfg_en  (fault_rst_en),
      .clr_we  (flag_clr_we),
      .clr_sel (flag_clr_sel),
      .flags   (flags),
      .rst_req (rst_req)
   );
endmodule

// File: tb/sim_ret_stack_guard.sv
module sim_ret_stack_guard;
   localparam int D = 31;

   logic        clk = 1'b0;
   logic        por_n = 1'b0, sys_rst_n = 1'b0;
   logic        push_req = 1'b0, pop_req = 1'b0;
   logic [20:0] push_addr = '0;
   logic        fault_rst_en = 1'b0, flag_clr_we = 1'b0;
   logic [1:0]  flag_clr_sel = '0;
   logic [20:0] pop_addr;
   logic [4:0]  depth_used;
   logic        full_flag, unf_flag, rst_req;

   int n_chk = 0, n_err = 0;
   bit done = 0;

   // reference model state
   int          m_cnt = 0;
   logic [20:0] m_stk [D];
   bit          m_full = 0, m_unf = 0, m_evq = 0, m_rq = 0;
   logic [20:0] m_pop = '0;

   always #2 clk = ~clk;

   ret_stack_guard u0 (
      .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n),
      .push_req(push_req), .pop_req(pop_req), .push_addr(push_addr),
      .fault_rst_en(fault_rst_en), .flag_clr_we(flag_clr_we),
      .flag_clr_sel(flag_clr_sel), .pop_addr(pop_addr),
      .depth_used(depth_used), .full_flag(full_flag),
      .unf_flag(unf_flag), .rst_req(rst_req)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic [20:0] rnd_addr();
      return 21'($urandom());
   endfunction

   task automatic compare_all();
      check("R1 depth", 32'(depth_used), 32'(m_cnt));
      check("R1 pop_addr", 32'(pop_addr), 32'(m_pop));
      check("R6 full_flag", 32'(full_flag), 32'(m_full));
      check("R6 unf_flag", 32'(unf_flag), 32'(m_unf));
      check("R4 rst_req", 32'(rst_req), 32'(m_rq));
   endtask

   // one clock with the given inputs; model advanced at the edge
   task automatic step(input bit ps, input bit pp, input logic [20:0] a,
                       input bit en, input bit cwe, input logic [1:0] cs);
      bit ff, fu;
      @(negedge clk);
      push_req = ps; pop_req = pp; push_addr = a;
      fault_rst_en = en; flag_clr_we = cwe; flag_clr_sel = cs;
      @(posedge clk);
      ff = 0; fu = 0;
      m_rq = m_evq;
      if (pp) begin
         if (m_cnt == 0) begin fu = 1; m_pop = '0; end
         else begin m_cnt--; m_pop = m_stk[m_cnt]; end
      end else if (ps) begin
         if (m_cnt >= D - 1) ff = 1;
         if (m_cnt < D) begin m_stk[m_cnt] = a; m_cnt++; end
      end
      m_evq = en & (ff | fu);
      if (cwe && cs[0]) m_full = 0;
      if (cwe && cs[1]) m_unf = 0;
      if (ff) m_full = 1;
      if (fu) m_unf = 1;
      #1;
      compare_all();
   endtask

   task automatic idle(input bit en);
      step(0, 0, '0, en, 0, 2'b00);
   endtask

   task automatic sys_reset();
      @(negedge clk);
      push_req = 0; pop_req = 0; flag_clr_we = 0;
      sys_rst_n = 0;
      #1;
      m_cnt = 0; m_pop = '0; m_evq = 0; m_rq = 0;
      check("R7 sys depth", 32'(depth_used), 32'd0);
      check("R7 sys rst_req", 32'(rst_req), 32'd0);
      check("R7 sys pop_addr", 32'(pop_addr), 32'd0);
      check("R7 sys full kept", 32'(full_flag), 32'(m_full));
      check("R7 sys unf kept", 32'(unf_flag), 32'(m_unf));
      @(negedge clk);
      sys_rst_n = 1;
   endtask

   task automatic po_reset();
      @(negedge clk);
      push_req = 0; pop_req = 0; flag_clr_we = 0;
      por_n = 0;
      #1;
      m_cnt = 0; m_pop = '0; m_evq = 0; m_rq = 0; m_full = 0; m_unf = 0;
      check("R7 por full", 32'(full_flag), 32'd0);
      check("R7 por unf", 32'(unf_flag), 32'd0);
      check("R7 por depth", 32'(depth_used), 32'd0);
      @(negedge clk);
      por_n = 1;
   endtask

   initial begin
      #(4 * 200000);
      if (!done) begin
         n_chk++; n_err++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      // reset state
      #1;
      check("R7 reset full", 32'(full_flag), 32'd0);
      check("R7 reset unf", 32'(unf_flag), 32'd0);
      check("R7 reset depth", 32'(depth_used), 32'd0);
      check("R7 reset rst_req", 32'(rst_req), 32'd0);
      repeat (2) @(negedge clk);
      por_n = 1; sys_rst_n = 1;

      // R1: LIFO order
      step(1, 0, 21'h0ABCD, 0, 0, 2'b00);
      step(1, 0, 21'h11111, 0, 0, 2'b00);
      step(1, 0, 21'h1F00F, 0, 0, 2'b00);
      step(0, 1, '0, 0, 0, 2'b00);
      check("R1 lifo first", 32'(pop_addr), 32'h1F00F);
      step(0, 1, '0, 0, 0, 2'b00);
      check("R1 lifo second", 32'(pop_addr), 32'h11111);
      step(0, 1, '0, 0, 0, 2'b00);
      check("R1 lifo third", 32'(pop_addr), 32'h0ABCD);
      idle(0);
      check("R1 pop_addr held", 32'(pop_addr), 32'h0ABCD);

      // R2 + R4: fill with reset request enabled
      for (int i = 0; i < D - 1; i++) step(1, 0, 21'(i + 100), 1, 0, 2'b00);
      check("R2 not full at 30", 32'(full_flag), 32'd0);
      step(1, 0, 21'h1ACE5, 1, 0, 2'b00);
      check("R2 full at 31", 32'(full_flag), 32'd1);
      check("R4 no req yet", 32'(rst_req), 32'd0);
      idle(0);
      check("R4 req pulse", 32'(rst_req), 32'd1);
      idle(0);
      check("R4 req single", 32'(rst_req), 32'd0);

      // R2 + R5: push at full, enable low
      step(0, 0, '0, 0, 1, 2'b01);
      check("R6 clear full", 32'(full_flag), 32'd0);
      step(1, 0, 21'h00BAD, 0, 0, 2'b00);
      check("R2 depth held", 32'(depth_used), 32'd31);
      check("R5 flag set", 32'(full_flag), 32'd1);
      idle(0);
      check("R5 no req", 32'(rst_req), 32'd0);
      idle(0);
      check("R5 no req late", 32'(rst_req), 32'd0);
      step(0, 1, '0, 0, 0, 2'b00);
      check("R2 no overwrite", 32'(pop_addr), 32'h1ACE5);

      // R7: ordinary reset keeps flags
      sys_reset();
      check("R7 full survives", 32'(full_flag), 32'd1);
      idle(0);

      // R6: select without strobe ignored
      step(0, 0, '0, 0, 0, 2'b11);
      check("R6 no strobe", 32'(full_flag), 32'd1);

      // R3: empty pop, reset request on
      step(0, 1, '0, 1, 0, 2'b00);
      check("R3 unf", 32'(unf_flag), 32'd1);
      check("R3 zero data", 32'(pop_addr), 32'd0);
      check("R3 depth", 32'(depth_used), 32'd0);
      idle(0);
      check("R4 unf req", 32'(rst_req), 32'd1);
      // R6: clear and fault together, fault wins
      step(0, 1, '0, 0, 1, 2'b10);
      check("R6 fault wins", 32'(unf_flag), 32'd1);
      step(0, 0, '0, 0, 1, 2'b11);
      check("R6 clear both unf", 32'(unf_flag), 32'd0);
      check("R6 clear both full", 32'(full_flag), 32'd0);

      // R8: simultaneous push and pop
      step(1, 0, 21'h02468, 0, 0, 2'b00);
      step(1, 1, 21'h13579, 0, 0, 2'b00);
      check("R8 pop done", 32'(pop_addr), 32'h02468);
      check("R8 push dropped", 32'(depth_used), 32'd0);

      // random mix
      for (int i = 0; i < 4000; i++) begin
         int r;
         bit ps, pp, cwe;
         r = int'($urandom_range(99));
         ps = (r < 50);
         pp = (r >= 40 && r < 85);
         cwe = ($urandom_range(19) == 0);
         step(ps, pp, rnd_addr(), 1'($urandom_range(1)), cwe, 2'($urandom_range(3)));
         if ($urandom_range(499) == 0) sys_reset();
      end

      // R7: power-on reset clears flags
      step(0, 1, '0, 0, 0, 2'b00);
      po_reset();
      idle(0);

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end
endmodule